// File: doc/BRIEF.md
# Interrupt Redirection Engine

The block watches a set of interrupt request lines and turns them into delivery messages for the interrupt controllers of the processors. Each line has its own entry: a configuration word (vector, delivery mode, destination mode, trigger mode, mask) and a destination word whose top byte names the target. The block records the last level it saw on every line, keeps a pending bit per line, and for level-triggered lines a remote-in-service flag that blocks further deliveries until an end-of-interrupt arrives for that vector.

Entries are written through a single write port (line number, word select, data) and can be read back through a combinational read port. Messages leave on a valid/ready channel and are held stable until accepted. An end-of-interrupt input carries a vector. It releases every level-triggered entry programmed with that vector, and such an entry is delivered again if its line is still asserted.

Top module: `irq_redirect_engine`

## Requirements
- R1: After reset every configuration word reads 0x0001_0000 (mask bit 16 set, all else zero), every destination word reads zero and msg_valid is low.
- R2: Only a low-to-high change of a line, relative to the level recorded on the previous clock, is acted on; a line held high produces no further message.
- R3: A rising line whose entry is edge-triggered (bit 15 = 0) and masked (bit 16 = 1) is discarded: unmasking the entry later yields no message.
- R4: A rising line on a masked level-triggered entry (bit 15 = 1) stays pending and is delivered once the entry is unmasked while the line is still high.
- R5: An edge-triggered entry sends one message per accepted rising edge; its pending bit clears only on dispatch, and a falling line leaves it set.
- R6: Dispatching a level-triggered entry sets its remote flag (configuration bit 14); while that flag is set the entry sends nothing.
- R7: A falling line on a level-triggered entry clears its pending bit, so a later end-of-interrupt sends nothing.
- R8: An end-of-interrupt with vector V clears the remote flag of every entry whose vector (bits 7:0) equals V; an entry still pending is then delivered again.
- R9: A message carries vector = bits 7:0, delivery mode = bits 10:8, destination mode = bit 11, level flag = bit 15 of the configuration word, and destination = bits 31:24 of the destination word.
- R10: Only delivery modes 0 (fixed) and 1 (lowest priority) are dispatched; an entry with any other mode keeps its pending bit and is delivered after its mode is changed to 0 or 1.
- R11: When several entries are ready, the lowest-numbered is sent first; a message is held unchanged while msg_valid is high and msg_ready is low.
- R12: Writes leave configuration bits 12 and 14 unchanged, bits 31:17 and 13 read as zero, and a destination write keeps only bits 31:24.
- R13: Configuration bit 12 (delivery status) reads 1 while the entry is ready but not yet dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Interrupt request lines, one per entry |
| wr_en | input | 1 | Write strobe for the entry table |
| wr_line | input | LW | Entry number to write |
| wr_dest | input | 1 | 1 selects the destination word, 0 the configuration word |
| wr_data | input | 32 | Write data |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| rd_line | input | LW | Entry number to read |
| rd_cfg_word | output | 32 | Configuration word of the selected entry |
| rd_dest_word | output | 32 | Destination word of the selected entry |
| msg_valid | output | 1 | A delivery message is offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode (0 or 1) |
| msg_dst_mode | output | 1 | Message destination mode |
| msg_level | output | 1 | 1 when the source entry is level-triggered |
| msg_dest | output | 8 | Destination byte |

## Verification
The assertions assume that a table write, a line change and an end-of-interrupt are all sampled on the clock edge, that irq_in is synchronous to clk, and that the receiver does not depend on msg_valid falling on its own. The stimulus changes every input only on the falling clock edge, draws vectors from a small pool so end-of-interrupts frequently match several entries, mixes undeliverable modes and random read-only bits into writes, and throttles msg_ready so messages back up behind the output register.

// File: rtl/redir_pkg.sv
package redir_pkg;
   localparam int VEC_W  = 8;
   localparam int MODE_W = 3;
   localparam int DEST_W = 8;
   localparam int WORD_W = 32;

   // bit positions inside the configuration and destination words
   localparam int B_VEC    = 0;
   localparam int B_MODE   = 8;
   localparam int B_DSTM   = 11;
   localparam int B_STATUS = 12;
   localparam int B_REMOTE = 14;
   localparam int B_TRIG   = 15;
   localparam int B_MASK   = 16;
   localparam int B_DEST   = 24;

   localparam logic [MODE_W-1:0] MODE_FIXED  = 3'd0;
   localparam logic [MODE_W-1:0] MODE_LOWPRI = 3'd1;

   typedef struct packed {
      logic              mask;
      logic              level;
      logic [MODE_W-1:0] mode;
      logic              dst_mode;
      logic [VEC_W-1:0]  vector;
   } redir_cfg_t;

   localparam redir_cfg_t CFG_RESET = '{mask: 1'b1, level: 1'b0, mode: '0,
                                        dst_mode: 1'b0, vector: '0};

   function automatic redir_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
      redir_cfg_t c;
      c.mask     = w[B_MASK];
      c.level    = w[B_TRIG];
      c.mode     = w[B_MODE +: MODE_W];
      c.dst_mode = w[B_DSTM];
      c.vector   = w[B_VEC +: VEC_W];
      return c;
   endfunction

   function automatic logic [WORD_W-1:0] cfg_to_word(input redir_cfg_t c,
                                                     input logic remote,
                                                     input logic status);
      logic [WORD_W-1:0] w;
      w = '0;
      w[B_VEC +: VEC_W]   = c.vector;
      w[B_MODE +: MODE_W] = c.mode;
      w[B_DSTM]           = c.dst_mode;
      w[B_STATUS]         = status;
      w[B_REMOTE]         = remote;
      w[B_TRIG]           = c.level;
      w[B_MASK]           = c.mask;
      return w;
   endfunction
endpackage

// File: rtl/redir_pick.sv
module redir_pick #(
   parameter  int N  = 24,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("redir_pick needs at least two requesters");
   end

   // scan from the top so the lowest set request is the last to win
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/redir_entry.sv
module redir_entry
   import redir_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_in,
   input  logic              cfg_we,
   input  logic              dst_we,
   input  logic [WORD_W-1:0] wdata,
   input  logic              eoi_valid,
   input  logic [VEC_W-1:0]  eoi_vector,
   input  logic              grant,
   output logic              ready,
   output redir_cfg_t        cfg,
   output logic [DEST_W-1:0] dest,
   output logic              remote
);
   redir_cfg_t        cfg_q;
   logic [DEST_W-1:0] dest_q;
   logic              last_q, irr_q, remote_q;
   logic              rise, fall, accept, mode_ok, eoi_hit;
   logic              irr_d, remote_d;

   assign rise    = line_in & ~last_q;
   assign fall    = ~line_in & last_q;
   // an edge on a masked edge-triggered entry is thrown away
   assign accept  = rise & ~(~cfg_q.level & cfg_q.mask);
   assign mode_ok = (cfg_q.mode == MODE_FIXED) || (cfg_q.mode == MODE_LOWPRI);
   assign eoi_hit = eoi_valid && (eoi_vector == cfg_q.vector);

   assign irr_d    = (irr_q & ~(grant & ~cfg_q.level) & ~(fall & cfg_q.level)) | accept;
   assign remote_d = (remote_q & ~eoi_hit) | (grant & cfg_q.level);

   assign ready  = irr_q & ~cfg_q.mask & mode_ok & ~(cfg_q.level & remote_q);
   assign cfg    = cfg_q;
   assign dest   = dest_q;
   assign remote = remote_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= CFG_RESET;
         dest_q   <= '0;
         last_q   <= 1'b0;
         irr_q    <= 1'b0;
         remote_q <= 1'b0;
      end else begin
         last_q   <= line_in;
         irr_q    <= irr_d;
         remote_q <= remote_d;
         if (cfg_we) cfg_q  <= cfg_from_word(wdata);
         if (dst_we) dest_q <= wdata[B_DEST +: DEST_W];
      end
   end

   a_r3_masked_edge_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !cfg_q.level && cfg_q.mask && !irr_q) |=> !irr_q);
   a_r6_remote_set_on_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && cfg_q.level) |=> remote_q);
   a_r6_no_grant_while_remote: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> !(cfg_q.level && remote_q));
   a_r7_level_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && cfg_q.level) |=> !irr_q);
   a_r10_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (cfg_q.mode == MODE_FIXED || cfg_q.mode == MODE_LOWPRI));
   a_r6_remote_only_by_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(remote_q) |-> $past(grant));
endmodule

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine
   import redir_pkg::*;
#(
   parameter  int NUM_LINES = 24,
   localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 wr_en,
   input  logic [LW-1:0]        wr_line,
   input  logic                 wr_dest,
   input  logic [WORD_W-1:0]    wr_data,
   input  logic                 eoi_valid,
   input  logic [VEC_W-1:0]     eoi_vector,
   input  logic [LW-1:0]        rd_line,
   output logic [WORD_W-1:0]    rd_cfg_word,
   output logic [WORD_W-1:0]    rd_dest_word,
   output logic                 msg_valid,
   input  logic                 msg_ready,
   output logic [VEC_W-1:0]     msg_vector,
   output logic [MODE_W-1:0]    msg_mode,
   output logic                 msg_dst_mode,
   output logic                 msg_level,
   output logic [DEST_W-1:0]    msg_dest
);
   if (NUM_LINES < 2 || NUM_LINES > 256) begin : g_bad_lines
      $error("NUM_LINES must lie in 2..256");
   end

   logic [NUM_LINES-1:0] ready, grant;
   redir_cfg_t           cfg_arr  [NUM_LINES];
   logic [DEST_W-1:0]    dest_arr [NUM_LINES];
   logic [WORD_W-1:0]    cfg_words[NUM_LINES];
   logic                 any_ready, load;
   logic [LW-1:0]        sel_idx;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic remote_i;
      redir_entry u_entry (
         .clk        (clk),
         .rst_n      (rst_n),
         .line_in    (irq_in[i]),
         .cfg_we     (wr_en && !wr_dest && (wr_line == LW'(i))),
         .dst_we     (wr_en &&  wr_dest && (wr_line == LW'(i))),
         .wdata      (wr_data),
         .eoi_valid  (eoi_valid),
         .eoi_vector (eoi_vector),
         .grant      (grant[i]),
         .ready      (ready[i]),
         .cfg        (cfg_arr[i]),
         .dest       (dest_arr[i]),
         .remote     (remote_i)
      );
      assign cfg_words[i] = cfg_to_word(cfg_arr[i], remote_i, ready[i]);
      assign grant[i]     = load && (sel_idx == LW'(i));
   end

   redir_pick #(.N(NUM_LINES)) u_pick (
      .req   (ready),
      .found (any_ready),
      .idx   (sel_idx)
   );

   // a new message is taken only when the output register is free or draining
   assign load = any_ready && (!msg_valid || msg_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid    <= 1'b0;
         msg_vector   <= '0;
         msg_mode     <= '0;
         msg_dst_mode <= 1'b0;
         msg_level    <= 1'b0;
         msg_dest     <= '0;
      end else if (load) begin
         msg_valid    <= 1'b1;
         msg_vector   <= cfg_arr[sel_idx].vector;
         msg_mode     <= cfg_arr[sel_idx].mode;
         msg_dst_mode <= cfg_arr[sel_idx].dst_mode;
         msg_level    <= cfg_arr[sel_idx].level;
         msg_dest     <= dest_arr[sel_idx];
      end else if (msg_ready) begin
         msg_valid    <= 1'b0;
      end
   end

   always_comb begin
      rd_cfg_word  = '0;
      rd_dest_word = '0;
      if (int'(rd_line) < NUM_LINES) begin
         rd_cfg_word                   = cfg_words[rd_line];
         rd_dest_word[B_DEST +: DEST_W] = dest_arr[rd_line];
      end
   end

   a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid &&
         $stable({msg_vector, msg_mode, msg_dst_mode, msg_level, msg_dest})));
   a_r11_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   a_r10_mode_out: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (msg_mode == MODE_FIXED || msg_mode == MODE_LOWPRI));
   a_r11_no_load_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |-> (grant == '0));
endmodule

// File: tb/tb_irq_redirect_engine.sv
`timescale 1ns/100ps
module tb_irq_redirect_engine;
   localparam int N  = 24;
   localparam int LW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic          wr_en = 1'b0;
   logic [LW-1:0] wr_line = '0;
   logic          wr_dest = 1'b0;
   logic [31:0]   wr_data = '0;
   logic          eoi_valid = 1'b0;
   logic [7:0]    eoi_vector = '0;
   logic [LW-1:0] rd_line = '0;
   logic [31:0]   rd_cfg_word, rd_dest_word;
   logic          msg_valid;
   logic          msg_ready = 1'b1;
   logic [7:0]    msg_vector;
   logic [2:0]    msg_mode;
   logic          msg_dst_mode, msg_level;
   logic [7:0]    msg_dest;

   always #2.5 clk = ~clk;

   irq_redirect_engine #(.NUM_LINES(N)) dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_line(wr_line),
      .wr_dest(wr_dest), .wr_data(wr_data), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .rd_line(rd_line), .rd_cfg_word(rd_cfg_word), .rd_dest_word(rd_dest_word),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
      .msg_mode(msg_mode), .msg_dst_mode(msg_dst_mode), .msg_level(msg_level),
      .msg_dest(msg_dest));

   int checks = 0, errors = 0, cyc = 0;
   bit started = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // ---------------- reference model built from the requirements ----------------
   bit [7:0] m_vec[N];  bit [2:0] m_mode[N]; bit m_dstm[N]; bit m_lvl[N];
   bit m_mask[N]; bit m_irr[N]; bit m_last[N]; bit m_rem[N]; bit [7:0] m_dest[N];
   bit m_valid; bit [7:0] p_vec; bit [2:0] p_mode; bit p_dstm; bit p_lvl; bit [7:0] p_dest;
   int m_sel; bit m_load, m_rise, m_fall, m_acc, m_g;

   function automatic bit m_rdy(input int i);
      return m_irr[i] && !m_mask[i] && (m_mode[i] <= 3'd1) && !(m_lvl[i] && m_rem[i]);
   endfunction

   function automatic logic [31:0] m_word(input int i);
      logic [31:0] w = '0;
      w[7:0] = m_vec[i]; w[10:8] = m_mode[i]; w[11] = m_dstm[i]; w[12] = m_rdy(i);
      w[14] = m_rem[i]; w[15] = m_lvl[i]; w[16] = m_mask[i];
      return w;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_vec[i] = 0; m_mode[i] = 0; m_dstm[i] = 0; m_lvl[i] = 0; m_mask[i] = 1;
            m_irr[i] = 0; m_last[i] = 0; m_rem[i] = 0; m_dest[i] = 0;
         end
         m_valid = 0;
      end else begin
         m_sel = -1;
         for (int i = N - 1; i >= 0; i--) if (m_rdy(i)) m_sel = i;
         m_load = (m_sel >= 0) && (!m_valid || msg_ready);
         if (m_load) begin
            m_valid = 1; p_vec = m_vec[m_sel]; p_mode = m_mode[m_sel];
            p_dstm = m_dstm[m_sel]; p_lvl = m_lvl[m_sel]; p_dest = m_dest[m_sel];
         end else if (msg_ready) m_valid = 0;
         for (int i = 0; i < N; i++) begin
            m_g    = m_load && (m_sel == i);
            m_rise = irq_in[i] && !m_last[i];
            m_fall = !irq_in[i] && m_last[i];
            m_acc  = m_rise && !(!m_lvl[i] && m_mask[i]);
            m_irr[i] = (m_irr[i] && !(m_g && !m_lvl[i]) && !(m_fall && m_lvl[i])) || m_acc;
            m_rem[i] = (m_rem[i] && !(eoi_valid && eoi_vector == m_vec[i])) || (m_g && m_lvl[i]);
            m_last[i] = irq_in[i];
            if (wr_en && int'(wr_line) == i) begin
               if (wr_dest) m_dest[i] = wr_data[31:24];
               else begin
                  m_vec[i] = wr_data[7:0]; m_mode[i] = wr_data[10:8]; m_dstm[i] = wr_data[11];
                  m_lvl[i] = wr_data[15]; m_mask[i] = wr_data[16];
               end
            end
         end
      end
   end

   // continuous comparison just after each edge
   always @(posedge clk) begin
      #1;
      if (rst_n && started) begin
         chk(msg_valid == m_valid, "R2 R5 R11", "msg_valid", msg_valid, m_valid);
         if (m_valid)
            chk({msg_vector, msg_mode, msg_dst_mode, msg_level, msg_dest} ==
                {p_vec, p_mode, p_dstm, p_lvl, p_dest}, "R9 R11", "message payload",
                {msg_vector, msg_mode, msg_dst_mode, msg_level, msg_dest},
                {p_vec, p_mode, p_dstm, p_lvl, p_dest});
         if (int'(rd_line) < N) begin
            chk(rd_cfg_word == m_word(int'(rd_line)), "R6 R12 R13", "config readback",
                rd_cfg_word, m_word(int'(rd_line)));
            chk(rd_dest_word == {m_dest[rd_line], 24'h0}, "R12", "dest readback",
                rd_dest_word, {m_dest[rd_line], 24'h0});
         end
      end
   end

   // accepted-message log
   int acc_cnt = 0; bit [7:0] acc_vec, acc_prev, acc_dest; bit acc_lvl;
   always @(posedge clk) begin
      if (rst_n && msg_valid && msg_ready) begin
         acc_cnt++; acc_prev = acc_vec; acc_vec = msg_vector;
         acc_dest = msg_dest; acc_lvl = msg_level;
      end
   end

   task automatic summary();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++; errors++;
         $display("FAIL R11 watchdog: actual %0d cycles expected fewer than 150000", cyc);
         summary();
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n); repeat (n) @(negedge clk); endtask

   task automatic wr(input int line, input bit dsel, input logic [31:0] d);
      @(negedge clk); wr_en = 1; wr_line = LW'(line); wr_dest = dsel; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic eoi(input logic [7:0] v);
      @(negedge clk); eoi_valid = 1; eoi_vector = v;
      @(negedge clk); eoi_valid = 0;
   endtask

   task automatic line(input int i, input bit v);
      @(negedge clk); irq_in[i] = v;
   endtask

   task automatic rd(input int i, output logic [31:0] c, output logic [31:0] d);
      @(negedge clk); rd_line = LW'(i); #1; c = rd_cfg_word; d = rd_dest_word;
   endtask

   logic [31:0] c, d;
   int base;

   initial begin
      void'($urandom(32'h1a2b3c4d));
      idle(4); rst_n = 1; started = 1;
      // R1 reset state
      chk(msg_valid == 0, "R1", "msg_valid after reset", msg_valid, 0);
      for (int i = 0; i < N; i += 7) begin
         rd(i, c, d);
         chk(c == 32'h0001_0000, "R1", "reset config word", c, 32'h0001_0000);
         chk(d == 0, "R1", "reset dest word", d, 0);
      end
      // R12 read-only and dropped bits
      wr(3, 1, 32'h5A00_1234);
      wr(3, 0, 32'h0010_7041);
      rd(3, c, d);
      chk(c == 32'h0000_0041, "R12", "config read-only bits", c, 32'h41);
      chk(d == 32'h5A00_0000, "R12", "dest low bits dropped", d, 32'h5A00_0000);
      // R5 R9 edge delivery, R2 held high
      base = acc_cnt;
      line(3, 1); idle(6);
      chk(acc_cnt == base + 1, "R5", "edge message count", acc_cnt, base + 1);
      chk({acc_vec, acc_dest, acc_lvl} == {8'h41, 8'h5A, 1'b0}, "R9", "edge message fields",
          {acc_vec, acc_dest, acc_lvl}, {8'h41, 8'h5A, 1'b0});
      idle(6);
      chk(acc_cnt == base + 1, "R2", "held high sends nothing", acc_cnt, base + 1);
      line(3, 0); idle(2); line(3, 1); idle(6);
      chk(acc_cnt == base + 2, "R2", "second rise sends again", acc_cnt, base + 2);
      // R3 masked edge dropped
      line(3, 0); wr(3, 0, 32'h0001_0041); line(3, 1); idle(3);
      wr(3, 0, 32'h0000_0041); idle(6);
      chk(acc_cnt == base + 2, "R3", "masked edge discarded", acc_cnt, base + 2);
      // R10 R5 undeliverable mode keeps pending through a fall
      line(3, 0); wr(3, 0, 32'h0000_0441); line(3, 1); idle(3);
      rd(3, c, d);
      chk(c == 32'h0000_0441, "R10", "mode 4 not ready", c, 32'h441);
      line(3, 0); idle(6);
      chk(acc_cnt == base + 2, "R10", "mode 4 not dispatched", acc_cnt, base + 2);
      wr(3, 0, 32'h0000_0141); idle(6);
      chk(acc_cnt == base + 3, "R5", "pending kept after fall", acc_cnt, base + 3);
      // R4 R6 R7 R8 level entry
      wr(7, 1, 32'h1100_0000); wr(7, 0, 32'h0001_8060);
      line(7, 1); idle(6);
      chk(acc_cnt == base + 3, "R4", "masked level held", acc_cnt, base + 3);
      wr(7, 0, 32'h0000_8060); idle(6);
      chk(acc_cnt == base + 4, "R4", "level delivered on unmask", acc_cnt, base + 4);
      chk({acc_vec, acc_dest, acc_lvl} == {8'h60, 8'h11, 1'b1}, "R9", "level message fields",
          {acc_vec, acc_dest, acc_lvl}, {8'h60, 8'h11, 1'b1});
      rd(7, c, d);
      chk(c == 32'h0000_C060, "R6", "remote flag set", c, 32'hC060);
      idle(6);
      chk(acc_cnt == base + 4, "R6", "no repeat while remote", acc_cnt, base + 4);
      eoi(8'h60); idle(6);
      chk(acc_cnt == base + 5, "R8", "redelivery after eoi", acc_cnt, base + 5);
      line(7, 0); idle(3); eoi(8'h60); idle(6);
      chk(acc_cnt == base + 5, "R7", "fall cleared pending", acc_cnt, base + 5);
      rd(7, c, d);
      chk(c == 32'h0000_8060, "R8", "remote cleared by eoi", c, 32'h8060);
      // R11 R13 priority and hold
      wr(2, 0, 32'h0000_0022); wr(9, 0, 32'h0000_0029);
      @(negedge clk); msg_ready = 0; irq_in[2] = 1; irq_in[9] = 1;
      idle(4);
      chk(msg_valid && msg_vector == 8'h22, "R11", "lowest line first", msg_vector, 8'h22);
      rd(9, c, d);
      chk(c == 32'h0000_1029, "R13", "waiting status bit", c, 32'h1029);
      idle(3);
      chk(msg_valid && msg_vector == 8'h22, "R11", "message held", msg_vector, 8'h22);
      @(negedge clk); msg_ready = 1; idle(6);
      chk({acc_prev, acc_vec} == {8'h22, 8'h29}, "R11", "delivery order",
          {acc_prev, acc_vec}, {8'h22, 8'h29});
      irq_in[2] = 0; irq_in[9] = 0;
      // random phase
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         irq_in    = irq_in ^ (N'(1) << ($urandom % N)) ^ (($urandom % 3 == 0) ? (N'(1) << ($urandom % N)) : '0);
         msg_ready = ($urandom % 10) < 7;
         rd_line   = LW'($urandom % N);
         eoi_valid = ($urandom % 10) == 0;
         eoi_vector = 8'h60 + 8'($urandom % 4);
         wr_en     = ($urandom % 5) == 0;
         wr_line   = LW'($urandom % N);
         wr_dest   = ($urandom % 4) == 0;
         wr_data   = $urandom;
         if (!wr_dest) begin
            wr_data[7:0]  = 8'h60 + 8'($urandom % 4);
            wr_data[10:8] = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'($urandom % 2);
            wr_data[16]   = ($urandom % 4) == 0;
         end
      end
      @(negedge clk); wr_en = 0; eoi_valid = 0; msg_ready = 1;
      idle(8);
      summary();
   end
endmodule